// File: doc/BRIEF.md
# Zero-Transition Address Bus Codec

This block links a processor-side address source to a memory-side consumer over a 16-bit address bus that has one extra sideband line. The encoder compares each new address with the last address it accepted. When the new address equals that address plus a fixed stride, the encoder leaves the address lines at their present value and raises the sideband line. Otherwise it places the address on the lines unchanged and lowers the sideband line.

The decoder keeps its own copy of the last address it produced. When the sideband line is high, it forms the next address from that copy plus the stride and ignores the address lines. When the sideband line is low, it takes the address lines as they are. A long run of in-order fetches therefore causes no switching on the address lines at all. Only the sideband line marks each transfer.

The top module holds both halves back to back and brings the bus lines out as ports, so that their activity can be observed. An address presented with `src_valid` appears on the bus one cycle later and at `dst_addr` two cycles later.

Top module: `zt_link_top`

## Requirements
- R1: While `rst` is high at a clock edge, and directly after it is released, `bus_valid`, `bus_seq` and `dst_valid` are 0, and `bus_addr` and `dst_addr` are 0x0000.
- R2: The first address accepted after reset is always sent with `bus_seq` = 0 and `bus_addr` equal to that address. This holds even when the address equals 0x0000 plus STRIDE.
- R3: When an accepted address equals the previously accepted address plus STRIDE (modulo 2^16), the next cycle shows `bus_seq` = 1 and `bus_addr` unchanged from its prior value.
- R4: When an accepted address is not in sequence, the next cycle shows `bus_seq` = 0 and `bus_addr` equal to that address.
- R5: Two cycles after an address is accepted, `dst_valid` is 1 for one cycle and `dst_addr` equals that address. This holds whether the transfer was frozen or explicit.
- R6: A cycle with `src_valid` = 0 leaves `bus_addr`, `bus_seq` and `dst_addr` unchanged and sets `bus_valid` to 0 in the next cycle. The sequence test for the next valid address still uses the last accepted address.
- R7: With STRIDE = 1, 0x0000 following 0xFFFF counts as in sequence.
- R8: After the first transfer of a purely sequential run, `bus_addr` shows zero bit toggles for the rest of the run.
- R9: `bus_valid` equals the value `src_valid` had one cycle earlier (outside reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Source presents an address this cycle |
| src_addr | input | 16 | Address from the source |
| bus_valid | output | 1 | Transfer present on the bus |
| bus_addr | output | 16 | Address lines of the bus |
| bus_seq | output | 1 | Sideband line, 1 = in-sequence transfer with frozen lines |
| dst_valid | output | 1 | Rebuilt address valid |
| dst_addr | output | 16 | Rebuilt address at the receiver |

## Verification
Two functions can meet in the same cycle: the stride-match test, and the rule that the first transfer after reset must be explicit. This happens when the first address after reset is exactly 0x0000 plus STRIDE. The bench sends that address right after reset and requires a low sideband line with the address on the lines. A second meeting point is the modulo wrap, where an address of 0x0000 must be judged in sequence after 0xFFFF. The bench judges both cases from its own model of the last accepted address, together with the end-to-end address comparison at the receiver.

// File: rtl/zt_pkg.sv
package zt_pkg;

    localparam int ADDR_W = 16;

    typedef logic [ADDR_W-1:0] addr_t;

    // What travels across the link in one transfer
    typedef struct packed {
        logic  seq;
        addr_t addr;
    } zt_word_t;

    typedef enum logic {
        ENC_COLD = 1'b0,   // no address accepted since reset
        ENC_WARM = 1'b1
    } enc_state_t;

    function automatic addr_t zt_advance(addr_t base, addr_t stride);
        return base + stride;
    endfunction

endpackage

// File: rtl/zt_seq_detect.sv
module zt_seq_detect
    import zt_pkg::*;
#(
    parameter int unsigned STRIDE = 1
) (
    input  enc_state_t state,
    input  addr_t      last_addr,
    input  addr_t      cand_addr,
    output logic       hit
);
    localparam addr_t STEP = addr_t'(STRIDE);

    addr_t expect_addr;

    always_comb begin
        expect_addr = zt_advance(last_addr, STEP);
        hit         = (state == ENC_WARM) && (cand_addr == expect_addr);
    end
endmodule

// File: rtl/zt_encoder.sv
module zt_encoder
    import zt_pkg::*;
#(
    parameter int unsigned STRIDE = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  addr_t    in_addr,
    output logic     out_valid,
    output zt_word_t out_word
);
    enc_state_t state_q;
    addr_t      last_q;
    logic       seq_hit;

    zt_seq_detect #(.STRIDE(STRIDE)) u_det (
        .state    (state_q),
        .last_addr(last_q),
        .cand_addr(in_addr),
        .hit      (seq_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ENC_COLD;
            last_q    <= '0;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                state_q      <= ENC_WARM;
                last_q       <= in_addr;
                out_word.seq <= seq_hit;
                if (!seq_hit) begin
                    out_word.addr <= in_addr;
                end
            end
        end
    end

    // R2
    first_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && state_q == ENC_COLD) |=> (!out_word.seq && out_word.addr == $past(in_addr)));

    // R3
    frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && seq_hit) |=> (out_word.seq && $stable(out_word.addr)));

    // R4
    plain_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !seq_hit) |=> (!out_word.seq && out_word.addr == $past(in_addr)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_word) && !out_valid && $stable(last_q)));
endmodule

// File: rtl/zt_decoder.sv
module zt_decoder
    import zt_pkg::*;
#(
    parameter int unsigned STRIDE = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  zt_word_t in_word,
    output logic     out_valid,
    output addr_t    out_addr
);
    localparam addr_t STEP = addr_t'(STRIDE);

    addr_t base_q;
    addr_t rebuilt;

    always_comb begin
        rebuilt = in_word.seq ? zt_advance(base_q, STEP) : in_word.addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                base_q   <= rebuilt;
                out_addr <= rebuilt;
            end
        end
    end

    // R6
    dec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_addr) && !out_valid));

    // R5
    dec_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_word.seq) |=> (out_addr == $past(in_word.addr)));
endmodule

// File: rtl/zt_link_top.sv
module zt_link_top
    import zt_pkg::*;
#(
    parameter int unsigned STRIDE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic [ADDR_W-1:0] src_addr,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_seq,
    output logic              dst_valid,
    output logic [ADDR_W-1:0] dst_addr
);
    zt_word_t link_word;

    zt_encoder #(.STRIDE(STRIDE)) u_enc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (src_valid),
        .in_addr  (src_addr),
        .out_valid(bus_valid),
        .out_word (link_word)
    );

    zt_decoder #(.STRIDE(STRIDE)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .in_valid (bus_valid),
        .in_word  (link_word),
        .out_valid(dst_valid),
        .out_addr (dst_addr)
    );

    assign bus_addr = link_word.addr;
    assign bus_seq  = link_word.seq;

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        src_valid |=> bus_valid);

    // R5
    end_to_end_chk: assert property (@(posedge clk) disable iff (rst)
        dst_valid |-> (dst_addr == $past(src_addr, 2)));
endmodule

// File: tb/sim_zt_link_top.sv
`timescale 1ns/1ps
module sim_zt_link_top;
    localparam int unsigned STRIDE = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_valid = 1'b0;
    logic [15:0] src_addr = '0;
    logic        bus_valid, bus_seq, dst_valid;
    logic [15:0] bus_addr, dst_addr;

    always #2.5 clk = ~clk;

    zt_link_top #(.STRIDE(STRIDE)) u0 (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_addr(src_addr),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_seq(bus_seq),
        .dst_valid(dst_valid), .dst_addr(dst_addr)
    );

    int n_chk = 0;
    int n_bad = 0;
    int toggles = 0;

    // bench model of what the outputs must show at the next check point
    bit          m_have;
    logic [15:0] m_last;
    bit          e_bv, e_bseq, e_dv;
    logic [15:0] e_baddr, e_bsrc, e_daddr, prev_bus;
    string       seq_lbl = "R3";
    string       first_lbl;

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_have = 0; m_last = '0;
        e_bv = 0; e_bseq = 0; e_dv = 0;
        e_baddr = '0; e_bsrc = '0; e_daddr = '0;
        prev_bus = '0;
    endtask

    // one cycle: check current outputs, then drive the next input
    task automatic step(bit v, logic [15:0] a);
        string lb;
        bit    sq;
        @(negedge clk);
        toggles += $countones(bus_addr ^ prev_bus);
        prev_bus = bus_addr;
        lb = !e_bv ? "R6" : (first_lbl != "" ? first_lbl : (e_bseq ? seq_lbl : "R4"));
        chk(bus_valid == e_bv, "R9", int'(bus_valid), int'(e_bv));
        chk(bus_seq == e_bseq, lb, int'(bus_seq), int'(e_bseq));
        chk(bus_addr == e_baddr, lb, int'(bus_addr), int'(e_baddr));
        chk(dst_valid == e_dv, "R5", int'(dst_valid), int'(e_dv));
        chk(dst_addr == e_daddr, e_dv ? "R5" : "R6", int'(dst_addr), int'(e_daddr));
        first_lbl = "";
        // advance model by one cycle
        e_dv = e_bv;
        if (e_bv) e_daddr = e_bsrc;
        e_bv = v;
        if (v) begin
            sq = m_have && (a == 16'(m_last + 16'(STRIDE)));
            if (!m_have) first_lbl = "R2";
            e_bseq = sq;
            if (!sq) e_baddr = a;
            e_bsrc = a;
            m_last = a;
            m_have = 1;
        end
        src_valid = v;
        src_addr  = a;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1; src_valid = 1; src_addr = 16'h1234;
        repeat (3) @(negedge clk);
        rst = 0; src_valid = 0;
        model_reset();
        @(negedge clk);
        // R1: state right after release
        chk(bus_valid == 0 && bus_seq == 0 && dst_valid == 0, "R1",
            {bus_valid, bus_seq, dst_valid}, 0);
        chk(bus_addr == 0 && dst_addr == 0, "R1", int'(bus_addr | dst_addr), 0);
    endtask

    // R2: first address equals reset value plus stride, must still go plain
    task automatic t_first_after_reset();
        t_reset();
        step(1, 16'(STRIDE));
        step(1, 16'(2 * STRIDE));
        step(0, '0);
        step(0, '0);
    endtask

    // R8: sequential run leaves address lines still
    task automatic t_seq_run(logic [15:0] base, int len);
        step(1, base);
        step(1, 16'(base + STRIDE));
        toggles = 0;
        for (int i = 2; i < len; i++) step(1, 16'(base + i * STRIDE));
        step(0, '0);
        step(0, '0);
        chk(toggles == 0, "R8", toggles, 0);
    endtask

    // R4: scattered addresses pass as plain binary
    task automatic t_jumps();
        step(1, 16'hA5A5); step(1, 16'h0F0F); step(1, 16'hA5A4);
        step(1, 16'h8000); step(1, 16'h0000);
        step(0, '0); step(0, '0);
    endtask

    // R6: idle gaps keep everything and sequence resumes from last accepted
    task automatic t_idle_gap();
        step(1, 16'h4000);
        step(0, 16'h7777); step(0, 16'h4001); step(0, '0);
        step(1, 16'h4001);
        step(0, '0); step(0, '0);
    endtask

    // R7: wrap-around at the top of the address space
    task automatic t_wrap();
        seq_lbl = "R7";
        step(1, 16'hFFFE); step(1, 16'hFFFF); step(1, 16'h0000); step(1, 16'h0001);
        step(0, '0); step(0, '0);
        seq_lbl = "R3";
    endtask

    // R3/R5: mixed stream, mostly sequential
    task automatic t_random_mix();
        logic [15:0] lfsr = 16'hACE1;
        logic [15:0] a = 16'h1000;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0)      a = lfsr ^ 16'h5A3C;
            else                        a = 16'(a + STRIDE);
            step(lfsr[4:3] != 2'b00, a);
        end
        step(0, '0); step(0, '0);
    endtask

    bit done = 0;

    initial begin
        first_lbl = "";
        model_reset();
        t_reset();
        t_first_after_reset();
        t_seq_run(16'h0100, 40);
        t_jumps();
        t_idle_gap();
        t_wrap();
        t_seq_run(16'hFFF0, 30);
        t_random_mix();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule